// File: doc/BRIEF.md
# Adaptive Duplex-to-Triple Redundancy Controller

This block supervises three identical functional units that compute the same result. After reset it runs them as a duplex pair. Units 1 and 2 are powered and compared, and unit 3 is held off as a cold spare. When the two online results disagree, the controller powers the spare and the external majority voter. It waits a short settle period while flagging the output as invalid, and then routes the voted word to the block output. In triple mode it records which unit the vote report blames, and those records stay set until reset.

The final output always comes from a four-way selector over the three unit results and the voted word. The controller drives the selector's code. A supervisor can use a strobed command to pin the block to any single selector input (simplex) or to send it back to duplex operation. A status word reports the mode, the output-invalid flag and the sticky per-unit fault flags. A bitwise pairwise mismatch report is also produced.

Top module: `redund_ctrl`

## Requirements
- R1: During and right after reset: unit enables = 3'b011, comparator enable = 1, voter enable = 0, select = 2'b00, status = 0.
- R2: The mismatch report holds u1^u2 in bits [W-1:0], u2^u3 in [2W-1:W] and u1^u3 in [3W-1:2W] while the comparator is enabled, and is all zeros otherwise.
- R3: In duplex (mode code 2'b00), if u1 differs from u2 at a clock edge with no accepted command, then from that edge onward: unit enables = 3'b111, voter enable = 1, comparator enable = 0, mode code 2'b01 and output-invalid (status bit 2) = 1.
- R4: The settle mode lasts exactly 2 cycles with select 2'b00. After it, the mode code is 2'b10 (triple), select = 2'b11, and output-invalid = 0.
- R5: The output equals unit 1, unit 2, unit 3 or the voted word for select 00, 01, 10 or 11 respectively, combinationally.
- R6: In triple mode a vote report of 3'b001, 3'b010 or 3'b100 sets status bit 3, 4 or 5 (units 1, 2, 3) at the next edge. Other report values set nothing. The flags are cleared only by reset.
- R7: An accepted command 3'b1ss enters simplex (mode code 2'b11) with select = ss. It enables only the chosen unit (all three and the voter for ss = 11) and disables the comparator.
- R8: An accepted command 3'b000 restores the duplex configuration of R1 and keeps the fault flags.
- R9: Commands with the valid strobe low, and codes 3'b001 to 3'b011, have no effect.
- R10: An accepted command takes priority over a mismatch seen at the same edge.
- R11: In duplex, differences on unit 3 alone do not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| u1_res | input | W | Unit 1 result |
| u2_res | input | W | Unit 2 result |
| u3_res | input | W | Unit 3 result |
| vote_word | input | W | Majority-voted word |
| vote_rpt | input | 3 | Voter report: one-hot names a single faulty unit |
| cmd_valid | input | 1 | Supervisor command strobe |
| cmd_code | input | 3 | Supervisor command |
| unit_en | output | 3 | Enables for units 3..1 |
| cmp_en | output | 1 | Mismatch comparator enable |
| vote_en | output | 1 | Voter enable |
| sel | output | 2 | Output selector code |
| y | output | W | Selected final output |
| mism_bits | output | 3*W | Bitwise pairwise mismatch report |
| status | output | 6 | {fault[3:1], out_invalid, mode[1:0]} |

## Verification
The bench drives a mismatch on the same edge as an accepted command. A design that let detection win would enter settle instead of simplex. It also holds units 1 and 2 equal while unit 3 differs, which catches a comparator that watches the spare. It counts the settle cycles exactly, so a design whose settle period is off by one would select the voter a cycle early or late. It sends the non-single vote reports 000, 101 and 111, and a duplex command after faults, to catch flags that set wrongly or clear on a mode change.

// File: rtl/redund_ctrl.sv
module redund_ctrl #(
  parameter int W = 8,
  parameter int SETTLE = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   u1_res,
  input  logic [W-1:0]   u2_res,
  input  logic [W-1:0]   u3_res,
  input  logic [W-1:0]   vote_word,
  input  logic [2:0]     vote_rpt,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_code,
  output logic [2:0]     unit_en,
  output logic           cmp_en,
  output logic           vote_en,
  output logic [1:0]     sel,
  output logic [W-1:0]   y,
  output logic [3*W-1:0] mism_bits,
  output logic [5:0]     status
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [1:0] M_DUP = 2'b00, M_SET = 2'b01, M_TMR = 2'b10, M_SIM = 2'b11;

  logic [1:0]    mode_q;
  logic [1:0]    sel_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    fault_q;

  wire cmd_dup = cmd_valid && (cmd_code == 3'b000);
  wire cmd_sim = cmd_valid && cmd_code[2];
  wire pair_diff = (u1_res != u2_res);
  wire single_rpt = (vote_rpt == 3'b001) || (vote_rpt == 3'b010) || (vote_rpt == 3'b100);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_DUP;
      sel_q   <= 2'b00;
      cnt_q   <= '0;
      fault_q <= 3'b000;
    end else begin
      if (mode_q == M_TMR && single_rpt)
        fault_q <= fault_q | vote_rpt;
      if (cmd_dup) begin
        mode_q <= M_DUP;
        sel_q  <= 2'b00;
      end else if (cmd_sim) begin
        mode_q <= M_SIM;
        sel_q  <= cmd_code[1:0];
      end else begin
        case (mode_q)
          M_DUP: if (pair_diff) begin
            mode_q <= M_SET;
            cnt_q  <= '0;
          end
          M_SET: if (cnt_q == CW'(SETTLE - 1)) begin
            mode_q <= M_TMR;
            sel_q  <= 2'b11;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (mode_q)
      M_DUP:   unit_en = 3'b011;
      M_SIM:   unit_en = (sel_q == 2'b11) ? 3'b111 : (3'b001 << sel_q);
      default: unit_en = 3'b111;
    endcase
  end

  assign cmp_en  = (mode_q == M_DUP);
  assign vote_en = (mode_q == M_SET) || (mode_q == M_TMR) || (mode_q == M_SIM && sel_q == 2'b11);
  assign sel     = sel_q;
  assign status  = {fault_q, mode_q == M_SET, mode_q};

  always_comb begin
    case (sel_q)
      2'b00:   y = u1_res;
      2'b01:   y = u2_res;
      2'b10:   y = u3_res;
      default: y = vote_word;
    endcase
  end

  assign mism_bits = cmp_en ? {u1_res ^ u3_res, u2_res ^ u3_res, u1_res ^ u2_res} : '0;

  assert_enter_tmr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DUP && pair_diff && !cmd_valid) |=> (vote_en && unit_en == 3'b111 && status[2]));

  assert_spare_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DUP && !pair_diff && !cmd_valid) |=> (mode_q == M_DUP && cmp_en));

  assert_tmr_after_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TMR && !$stable(mode_q) && !$past(cmd_valid)) |-> ($past(mode_q) == M_SET && sel == 2'b11));

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((fault_q & $past(fault_q)) == $past(fault_q)));

  assert_cmd_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[2]) |=> (sel == $past(cmd_code[1:0]) && !cmp_en));

  assert_cmd_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DUP && pair_diff && cmd_valid && cmd_code == 3'b000) |=> (mode_q == M_DUP));
endmodule

// File: tb/sim_redund_ctrl.sv
module sim_redund_ctrl;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] u1 = '0, u2 = '0, u3 = '0, vw = '0;
  logic [2:0] rpt = 3'b000, cmd = 3'b000;
  logic cv = 1'b0;
  logic [2:0] unit_en; logic cmp_en, vote_en; logic [1:0] sel;
  logic [W-1:0] y; logic [3*W-1:0] mism; logic [5:0] status;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_mode = 0, m_sel = 0, m_cnt = 0, m_fault = 0;

  always #5 clk = ~clk;

  redund_ctrl #(.W(W), .SETTLE(2)) u0 (
    .clk(clk), .rst_n(rst_n), .u1_res(u1), .u2_res(u2), .u3_res(u3), .vote_word(vw),
    .vote_rpt(rpt), .cmd_valid(cv), .cmd_code(cmd), .unit_en(unit_en), .cmp_en(cmp_en),
    .vote_en(vote_en), .sel(sel), .y(y), .mism_bits(mism), .status(status));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_sel = 0; m_cnt = 0; m_fault = 0;
    end else begin
      if (m_mode == 2 && (rpt == 3'b001 || rpt == 3'b010 || rpt == 3'b100)) m_fault = m_fault | rpt;
      if (cv && cmd == 3'b000) begin m_mode = 0; m_sel = 0; end
      else if (cv && cmd[2]) begin m_mode = 3; m_sel = cmd[1:0]; end
      else if (m_mode == 0 && u1 != u2) begin m_mode = 1; m_cnt = 0; end
      else if (m_mode == 1) begin
        if (m_cnt == 1) begin m_mode = 2; m_sel = 3; end else m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [2:0] e_en; logic e_ve; logic [W-1:0] e_y; logic [3*W-1:0] e_m;
    if (m_mode == 0) e_en = 3'b011;
    else if (m_mode == 3 && m_sel != 3) e_en = 3'(1 << m_sel);
    else e_en = 3'b111;
    e_ve = (m_mode == 1 || m_mode == 2 || (m_mode == 3 && m_sel == 3));
    e_y = (m_sel == 0) ? u1 : (m_sel == 1) ? u2 : (m_sel == 2) ? u3 : vw;
    e_m = (m_mode == 0) ? {u1 ^ u3, u2 ^ u3, u1 ^ u2} : '0;
    chk("R3/R7 unit_en", unit_en, e_en);
    chk("R3/R8 cmp_en", cmp_en, m_mode == 0);
    chk("R3/R7 vote_en", vote_en, e_ve);
    chk("R4/R7 sel", sel, m_sel);
    chk("R5 y", y, e_y);
    chk("R2 mism_bits", mism, e_m);
    chk("R6 status fault", status[5:3], m_fault);
    chk("R4 status invalid", status[2], m_mode == 1);
    chk("R10/R11 status mode", status[1:0], m_mode);
  endtask

  task automatic step(input logic [W-1:0] a, b, c, v, input logic [2:0] r,
                      input logic valid, input logic [2:0] code);
    @(negedge clk);
    compare_all();
    u1 = a; u2 = b; u3 = c; vw = v; rpt = r; cv = valid; cmd = code;
    cyc++;
  endtask

  task automatic rnd_steps(input int n, input bit diff12);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] a;
      a = W'($urandom);
      step(a, diff12 ? W'($urandom) : a, W'($urandom), W'($urandom), 3'($urandom), 1'b0, 3'($urandom));
    end
  endtask

  initial begin
    #2;
    // R1: reset values
    compare_all();
    chk("R1 reset unit_en", unit_en, 3'b011);
    chk("R1 reset status", status, 0);
    #20 rst_n = 1'b1;
    // R11: unit 3 alone differs
    step(8'h11, 8'h11, 8'h99, 8'h00, 3'b001, 1'b0, 3'b000);
    step(8'h22, 8'h22, 8'h55, 8'h00, 3'b000, 1'b0, 3'b000);
    // R9: invalid strobe and reserved codes
    step(8'h33, 8'h33, 8'h33, 8'h00, 3'b000, 1'b0, 3'b110);
    step(8'h33, 8'h33, 8'h33, 8'h00, 3'b000, 1'b1, 3'b001);
    step(8'h33, 8'h33, 8'h33, 8'h00, 3'b000, 1'b1, 3'b011);
    // R3/R4: mismatch, settle, triple
    step(8'h40, 8'h41, 8'h40, 8'h40, 3'b000, 1'b0, 3'b000);
    step(8'h40, 8'h40, 8'h40, 8'h40, 3'b000, 1'b0, 3'b000);
    step(8'h40, 8'h40, 8'h40, 8'h40, 3'b000, 1'b0, 3'b000);
    step(8'h40, 8'h40, 8'h40, 8'h40, 3'b000, 1'b0, 3'b000);
    // R6: non-single reports, then single ones
    step(8'h01, 8'h02, 8'h03, 8'hAA, 3'b111, 1'b0, 3'b000);
    step(8'h01, 8'h02, 8'h03, 8'hAB, 3'b101, 1'b0, 3'b000);
    step(8'h01, 8'h02, 8'h03, 8'hAC, 3'b010, 1'b0, 3'b000);
    step(8'h01, 8'h02, 8'h03, 8'hAD, 3'b000, 1'b0, 3'b000);
    step(8'h01, 8'h02, 8'h03, 8'hAE, 3'b100, 1'b0, 3'b000);
    rnd_steps(20, 1'b1);
    // R7: each simplex select
    for (int s = 0; s < 4; s++) begin
      step(8'h5A, 8'hA5, 8'h3C, 8'hC3, 3'b001, 1'b1, 3'(4 + s));
      step(8'h5B, 8'hA6, 8'h3D, 8'hC4, 3'b001, 1'b0, 3'b000);
    end
    // R8: back to duplex, faults kept
    step(8'h10, 8'h10, 8'h20, 8'h00, 3'b000, 1'b1, 3'b000);
    step(8'h10, 8'h10, 8'h20, 8'h00, 3'b000, 1'b0, 3'b000);
    // R10: mismatch with simultaneous commands
    step(8'h10, 8'h11, 8'h20, 8'h00, 3'b000, 1'b1, 3'b000);
    step(8'h10, 8'h11, 8'h20, 8'h00, 3'b000, 1'b1, 3'b110);
    step(8'h10, 8'h10, 8'h20, 8'h00, 3'b000, 1'b1, 3'b000);
    rnd_steps(30, 1'b0);
    rnd_steps(40, 1'b1);
    step(8'h00, 8'h00, 8'h00, 8'h00, 3'b000, 1'b1, 3'b000);
    rnd_steps(60, 1'b0);
    step(8'h00, 8'h00, 8'h00, 8'h00, 3'b000, 1'b0, 3'b000);
    @(negedge clk);
    compare_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule